// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Handshaked Settings Commit

This block drives one pulse-width-modulated output per channel. Each channel's waveform is shaped by four settings: a clock prescale, a period count, a duty-high count and a polarity select. Software writes these settings over a small register bus into shadow registers. The running waveform never sees a shadow value directly. New values reach a channel's generator only after a per-channel trigger/smooth handshake with minimum low and high times. The generator then takes them at the next period boundary, so no cut-short or stretched period ever appears on the pin.

There is no separate enable. A channel is switched off by committing zero period, zero duty and zero prescale, which parks the output at its inactive level. The minimum handshake times are set by a parameter counted in system-clock cycles. The default of 100 cycles gives 400 ns at 250 MHz.

Top module: `pwm_multi_top`

## Requirements
- R1: After reset every register reads as zero and every PWM output is low.
- R2: The bus address map is: 0 is the control word, 1 is the prescale word, 2+2c is the period of channel c, and 3+2c is the duty of channel c. In the control word, bit c is the trigger of channel c, bit NCH+c is its smooth bit and bit 2*NCH+c is its polarity. In the prescale word, bits [PRE_W*c +: PRE_W] hold the prescale of channel c. A write followed by a read of the same address returns the written value one cycle after the read address is presented.
- R3: Writing shadow prescale, period, duty or polarity without a valid handshake leaves the running waveform unchanged.
- R4: A rising trigger is accepted only if the trigger has been low for at least HOLD_CYC cycles. A rising trigger that comes earlier commits nothing.
- R5: An accepted trigger must stay high for HOLD_CYC further cycles. If it falls before then, nothing is committed.
- R6: Clearing the trigger while smooth is set keeps the channel on its committed settings. If smooth is still set when the high time expires, nothing is committed.
- R7: After a commit, a channel with 0 < duty < period emits a high time of duty*(prescale+1) cycles and a period of period*(prescale+1) cycles.
- R8: A committed duty at or above a nonzero period gives a constant active output.
- R9: Committing zero period, zero duty and zero prescale gives a constant inactive output, which is low for normal polarity.
- R10: With the polarity bit set to 1, the output is inverted. The low time becomes duty*(prescale+1) cycles.
- R11: A commit takes effect only at a period boundary. A pulse already in progress finishes with its old width.
- R12: A commit on one channel does not alter the waveform of any other channel.
- R13: The channel counter advances once every prescale+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a commit that lands in the middle of a running high pulse. It is what shows whether the generator defers new settings to the period boundary. The stimulus prepares a long-period channel with the new shadow values already written. It then watches for that channel's output to rise and raises the trigger in that same cycle, so the commit fires partway through the high phase. The bench then measures the width of that pulse and of the one after it. Handshakes that are too short and handshakes with smooth still set are driven the same way, and each is followed by a waveform measurement showing the old settings survived.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_HIGH  = 2'd1,
    TS_SPENT = 2'd2
  } trig_state_t;

  function automatic int period_addr(input int ch);
    return 2 + 2 * ch;
  endfunction

  function automatic int duty_addr(input int ch);
    return 3 + 2 * ch;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_multi_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NCH-1:0]              sh_trig,
  output logic [NCH-1:0]              sh_smooth,
  output logic [NCH-1:0]              sh_pol,
  output logic [NCH-1:0][PRE_W-1:0]   sh_pre,
  output logic [NCH-1:0][CNT_W-1:0]   sh_per,
  output logic [NCH-1:0][CNT_W-1:0]   sh_duty
);

  localparam int CTRL_W = 3 * NCH;
  localparam int PREW_W = NCH * PRE_W;

  logic [CTRL_W-1:0]         ctrl_r;
  logic [PREW_W-1:0]         pre_r;
  logic [NCH-1:0][CNT_W-1:0] per_r;
  logic [NCH-1:0][CNT_W-1:0] duty_r;
  logic [DATA_W-1:0]         rd_next;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= '0;
      pre_r  <= '0;
      per_r  <= '0;
      duty_r <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(0)) ctrl_r <= wdata[CTRL_W-1:0];
      if (addr == ADDR_W'(1)) pre_r  <= wdata[PREW_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (addr == ADDR_W'(period_addr(c))) per_r[c]  <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(duty_addr(c)))   duty_r[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(0)) rd_next[CTRL_W-1:0] = ctrl_r;
    if (addr == ADDR_W'(1)) rd_next[PREW_W-1:0] = pre_r;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(period_addr(c))) rd_next[CNT_W-1:0] = per_r[c];
      if (addr == ADDR_W'(duty_addr(c)))   rd_next[CNT_W-1:0] = duty_r[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign sh_trig   = ctrl_r[NCH-1:0];
  assign sh_smooth = ctrl_r[2*NCH-1:NCH];
  assign sh_pol    = ctrl_r[3*NCH-1:2*NCH];
  assign sh_pre    = pre_r;
  assign sh_per    = per_r;
  assign sh_duty   = duty_r;

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(0)) |=> (sh_trig == $past(wdata[NCH-1:0])));

endmodule

// File: rtl/pwm_trig_sync.sv
module pwm_trig_sync
  import pwm_multi_pkg::*;
#(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic smooth,
  output logic commit
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  trig_state_t   st;
  logic          trig_q;
  logic [HW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;
  logic          low_done;
  logic          rise;

  assign low_done = (low_cnt == HW'(HOLD_CYC));
  assign rise     = trig && !trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TS_IDLE;
      trig_q  <= 1'b0;
      low_cnt <= '0;
      hi_cnt  <= '0;
      commit  <= 1'b0;
    end else begin
      trig_q <= trig;
      commit <= 1'b0;
      if (!trig) begin
        if (!low_done) low_cnt <= low_cnt + HW'(1);
      end else begin
        low_cnt <= '0;
      end
      case (st)
        TS_IDLE: begin
          if (rise) begin
            if (low_done) begin
              st     <= TS_HIGH;
              hi_cnt <= HW'(1);
            end else begin
              st <= TS_SPENT;
            end
          end
        end
        TS_HIGH: begin
          if (!trig) begin
            st <= TS_IDLE;
          end else if (hi_cnt == HW'(HOLD_CYC)) begin
            commit <= !smooth;
            st     <= TS_SPENT;
          end else begin
            hi_cnt <= hi_cnt + HW'(1);
          end
        end
        default: begin
          if (!trig) st <= TS_IDLE;
        end
      endcase
    end
  end

  // R5
  commit_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(trig));

  // R6
  commit_needs_smooth_low_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> !$past(smooth));

  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [PRE_W-1:0] sh_pre,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic             sh_pol,
  output logic             pwm_out
);

  logic [PRE_W-1:0] act_pre, stg_pre, pre_cnt;
  logic [CNT_W-1:0] act_per, stg_per, act_duty, stg_duty, cnt;
  logic             act_pol, stg_pol, pend;
  logic             tick, last, raw;

  assign tick = (pre_cnt == act_pre);
  assign last = (act_per == '0) || (tick && (cnt >= act_per - CNT_W'(1)));
  assign raw  = (act_per != '0) && (cnt < act_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_pol  <= 1'b0;
      stg_pre  <= '0;
      stg_per  <= '0;
      stg_duty <= '0;
      stg_pol  <= 1'b0;
      pend     <= 1'b0;
      pre_cnt  <= '0;
      cnt      <= '0;
      pwm_out  <= 1'b0;
    end else begin
      pwm_out <= raw ^ act_pol;
      if (last) begin
        cnt     <= '0;
        pre_cnt <= '0;
        if (pend) begin
          act_pre  <= stg_pre;
          act_per  <= stg_per;
          act_duty <= stg_duty;
          act_pol  <= stg_pol;
          pend     <= 1'b0;
        end
      end else if (tick) begin
        pre_cnt <= '0;
        cnt     <= cnt + CNT_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
      if (commit) begin
        stg_pre  <= sh_pre;
        stg_per  <= sh_per;
        stg_duty <= sh_duty;
        stg_pol  <= sh_pol;
        pend     <= 1'b1;
      end
    end
  end

  // R11
  load_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_pre, act_per, act_duty, act_pol}) |-> $past(pend));

  // R8
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0 && act_duty >= act_per) |=> (pwm_out != $past(act_pol)));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per == '0) |=> (pwm_out == $past(act_pol)));

  // R13
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !last && !commit && !pend) |=> $stable(cnt));

endmodule

// File: rtl/pwm_multi_top.sv
module pwm_multi_top #(
  parameter int NCH      = 4,
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int DATA_W   = 32,
  parameter int HOLD_CYC = 100,
  parameter int ADDR_W   = $clog2(2 + 2 * NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  logic [NCH-1:0]            sh_trig, sh_smooth, sh_pol, commit;
  logic [NCH-1:0][PRE_W-1:0] sh_pre;
  logic [NCH-1:0][CNT_W-1:0] sh_per, sh_duty;

  pwm_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .sh_trig(sh_trig), .sh_smooth(sh_smooth),
    .sh_pol(sh_pol), .sh_pre(sh_pre), .sh_per(sh_per), .sh_duty(sh_duty)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_trig_sync #(.HOLD_CYC(HOLD_CYC)) u_trig (
      .clk(clk), .rst(rst), .trig(sh_trig[c]), .smooth(sh_smooth[c]),
      .commit(commit[c])
    );

    pwm_chan_gen #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_gen (
      .clk(clk), .rst(rst), .commit(commit[c]), .sh_pre(sh_pre[c]),
      .sh_per(sh_per[c]), .sh_duty(sh_duty[c]), .sh_pol(sh_pol[c]),
      .pwm_out(pwm_out[c])
    );
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) $past(rst) |-> (pwm_out == '0));

endmodule

// File: tb/sim_pwm_multi_top.sv
module sim_pwm_multi_top;

  localparam int NCH  = 4;
  localparam int HOLD = 10;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] ctrl_v = '0;
  logic [31:0] pre_v = '0;

  pwm_multi_top #(.NCH(NCH), .CNT_W(16), .PRE_W(8), .DATA_W(32), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input int ch, input bit t, input bit s);
    ctrl_v[ch] = t;
    ctrl_v[NCH + ch] = s;
    wr(0, ctrl_v);
  endtask

  task automatic cfg(input int ch, input int pre, input int per, input int duty, input bit pol);
    pre_v[ch*8 +: 8] = 8'(pre);
    ctrl_v[2*NCH + ch] = pol;
    wr(1, pre_v);
    wr(2 + 2*ch, 32'(per));
    wr(3 + 2*ch, 32'(duty));
  endtask

  task automatic commit(input int ch);
    set_ctrl(ch, 1'b0, 1'b1);
    idle(HOLD + 3);
    set_ctrl(ch, 1'b1, 1'b0);
    idle(HOLD + 3);
  endtask

  task automatic measure(input int ch, input bit inv, output int hi, output int per);
    bit lv, pv;
    int t;
    hi = 0; per = 0; t = 0;
    @(negedge clk);
    pv = pwm_out[ch] ^ inv;
    while (t < 4000) begin
      @(negedge clk); t++;
      lv = pwm_out[ch] ^ inv;
      if (lv && !pv) break;
      pv = lv;
    end
    if (t >= 4000) return;
    hi = 1; per = 1;
    while (per < 4000) begin
      @(negedge clk);
      lv = pwm_out[ch] ^ inv;
      if (!lv) break;
      hi++; per++;
    end
    while (per < 4000) begin
      per++;
      @(negedge clk);
      lv = pwm_out[ch] ^ inv;
      if (lv) break;
    end
  endtask

  task automatic wave(input string req, input int ch, input bit inv, input int ehi, input int eper);
    int hi, per;
    measure(ch, inv, hi, per);
    chk({req, " active time"}, hi, ehi);
    chk({req, " period"}, per, eper);
  endtask

  task automatic level(input string req, input int ch, input bit lvl, input int n);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) bad++;
    end
    chk({req, " off-level samples"}, bad, 0);
  endtask

  initial begin
    logic [31:0] d;
    int hi;
    bit pv;
    void'($urandom(32'd20150612));
    idle(5);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", int'(pwm_out), 0);
    for (int a = 0; a < 10; a++) begin
      rd(a, d);
      chk("R1 register read", int'(d), 0);
    end

    // R7 and R13: channel 0 with prescale 1
    cfg(0, 1, 12, 4, 1'b0);
    commit(0);
    wave("R7 R13 ch0", 0, 1'b0, 8, 24);

    // R10: channel 1 inverted
    cfg(1, 0, 10, 3, 1'b1);
    commit(1);
    wave("R10 ch1 inverted", 1, 1'b1, 3, 10);

    // R2: shadow readback
    wr(2, 32'd30);
    wr(3, 32'd9);
    rd(2, d); chk("R2 period readback", int'(d), 30);
    rd(3, d); chk("R2 duty readback", int'(d), 9);
    rd(1, d); chk("R2 prescale readback", int'(d), int'(pre_v));
    rd(0, d); chk("R2 control readback", int'(d), int'(ctrl_v));

    // R3: shadow writes alone leave the waveform
    wave("R3 ch0 unchanged", 0, 1'b0, 8, 24);

    // R6: trigger low with smooth set, then a handshake with smooth set
    set_ctrl(0, 1'b0, 1'b1);
    wave("R6 ch0 after prepare", 0, 1'b0, 8, 24);
    set_ctrl(0, 1'b1, 1'b1);
    idle(HOLD + 10);
    wave("R6 ch0 smooth held", 0, 1'b0, 8, 24);

    // R4: low time too short
    set_ctrl(0, 1'b0, 1'b1);
    idle(2);
    set_ctrl(0, 1'b1, 1'b0);
    idle(HOLD + 20);
    wave("R4 ch0 short low", 0, 1'b0, 8, 24);

    // R5: high time too short
    set_ctrl(0, 1'b0, 1'b1);
    idle(HOLD + 10);
    set_ctrl(0, 1'b1, 1'b0);
    idle(2);
    set_ctrl(0, 1'b0, 1'b0);
    idle(HOLD + 20);
    wave("R5 ch0 short high", 0, 1'b0, 8, 24);

    // R7: valid commit applies period 30 duty 9 prescale 1
    commit(0);
    wave("R7 ch0 new settings", 0, 1'b0, 18, 60);

    // R12: channel 1 untouched
    wave("R12 ch1 unchanged", 1, 1'b1, 3, 10);

    // R11: commit lands in the middle of a high pulse
    cfg(2, 0, 40, 20, 1'b0);
    commit(2);
    wave("R11 ch2 old", 2, 1'b0, 20, 40);
    set_ctrl(2, 1'b0, 1'b1);
    wr(4 + 2, 32'd10);
    wr(5 + 2, 32'd5);
    idle(HOLD + 3);
    @(negedge clk);
    pv = pwm_out[2];
    while (!(pwm_out[2] && !pv)) begin
      pv = pwm_out[2];
      @(negedge clk);
    end
    ctrl_v[2] = 1'b1; ctrl_v[NCH + 2] = 1'b0;
    bus_wr = 1'b1; bus_addr = AW'(0); bus_wdata = ctrl_v;
    hi = 1;
    @(negedge clk);
    bus_wr = 1'b0;
    while (pwm_out[2] && hi < 200) begin
      hi++;
      @(negedge clk);
    end
    chk("R11 pulse in progress keeps old width", hi, 20);
    wave("R11 ch2 after boundary", 2, 1'b0, 5, 10);

    // R8: duty above period gives constant high
    cfg(3, 2, 6, 9, 1'b0);
    commit(3);
    idle(100);
    level("R8 ch3 full duty", 3, 1'b1, 60);

    // R9: all-zero settings disable channel 0
    cfg(0, 0, 0, 0, 1'b0);
    commit(0);
    idle(200);
    level("R9 ch0 disabled", 0, 1'b0, 60);

    // R7: random settings on channel 3
    for (int i = 0; i < 6; i++) begin
      int p, pr, du;
      pr = int'($urandom % 4);
      p  = 2 + int'($urandom % 19);
      du = 1 + int'($urandom % (p - 1));
      cfg(3, pr, p, du, 1'b0);
      commit(3);
      wave("R7 ch3 random", 3, 1'b0, du * (pr + 1), p * (pr + 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule